// File: doc/BRIEF.md
# Q and S Wave Locator

This block takes a stream of band-pass filtered ECG samples, together with a strobe that marks the sample where a confirmed R peak sits. After a peak it gathers the samples on both sides of it. It then looks for the Q point among the samples before the peak and for the S point among the samples after it. For each side it reports whether a point was found, the sample value at that point, and how many samples the point lies from the R peak.

The rules are the same on both sides. A sample qualifies when the slope into it or out of it is zero, or when the slope flips sign at that sample. A sample also qualifies when three consecutive slopes around it are all steeper than a dynamic threshold. That threshold is derived from the steepest rising slope and the steepest falling slope in the complex. Each search starts next to the peak and moves outward, so the first qualifying sample is the one reported. While the search runs the block is busy and takes no input. It is meant to follow a peak detector in a low-rate ECG pipeline: at 250 Hz, a 20-sample window covers 80 ms.

Top module: `qs_locator`

## Requirements
- R1: Each search window holds W samples (default 20). The Q window covers the samples 1..W before the peak and the S window covers the samples 1..W after it. The reported offset is this distance, 1..W, counted in samples.
- R2: Criterion one: a sample x is a candidate when the slope into it (x minus the sample before it, in time) is zero, or the slope out of it (the next sample minus x) is zero, or these two slopes are nonzero and of opposite sign.
- R3: Criterion two: a sample x is a candidate when three slopes all have a magnitude strictly greater than THR: the slope into the sample before x, the slope into x, and the slope out of x. THR is the smaller of two values, shifted right by 3 (floor of one eighth). The two values are the largest positive slope and the largest negative slope magnitude among the 2W consecutive slopes that end at offsets -W+1..+W. A value with no slope of its sign counts as 0.
- R4: A sample that meets either criterion is a candidate. The reported point is the candidate with the smallest offset.
- R5: When a window has no candidate, its found flag is 0, its amplitude is 0 and its offset is 0. When a point is found, the flag is 1 and the amplitude is that sample's value.
- R6: A sample is accepted when smp_vld is high and busy is low. A peak strobe is honoured only if at least W+2 samples were accepted before it, counted since reset or since the last result. A strobe that arrives while an earlier peak is still collecting its trailing samples is ignored.
- R7: The W+2 accepted samples after an honoured peak complete the frame, and busy rises on the clock edge that accepts the last of them. busy stays high until the result appears. Samples and strobes presented while busy is high have no effect on any result.
- R8: res_vld is a single-cycle pulse. The six result outputs change only together with it and hold their values until the next pulse. After reset, busy, res_vld and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A sample is present on smp |
| smp | input | DW | Filtered ECG sample, signed |
| pk_in | input | 1 | The sample on smp is a confirmed R peak |
| busy | output | 1 | Search running; input is not taken |
| res_vld | output | 1 | One-cycle pulse when a new result is on the outputs |
| q_fnd | output | 1 | A Q point was found |
| q_amp | output | DW | Q point sample value, signed; 0 if not found |
| q_off | output | $clog2(W+1) | Q point distance before the peak, in samples |
| s_fnd | output | 1 | An S point was found |
| s_amp | output | DW | S point sample value, signed; 0 if not found |
| s_off | output | $clog2(W+1) | S point distance after the peak, in samples |

## Verification
The bench checks each result against a bench-side model of the two criteria. Three kinds of seeded random frames are used. White-noise frames trigger the sign-change rule right next to the peak. Monotone rise-and-fall frames with occasional flat steps make the zero-slope rule and the steep-slope rule compete over different distances. Small noise around a tall spike keeps the threshold high. Directed frames isolate single behaviours. A pure ramp gives a zero threshold. A slope-one shoulder around a sharp spike gives no candidate at all. A lone flat step at the far edge places the point exactly at offset W. Full-scale alternating samples test slope arithmetic at the ends of the range. Further sequences check that an early strobe, a second strobe while collecting, and input presented while busy all leave the outcome unchanged.

// File: rtl/qs_pkg.sv
package qs_pkg;
   typedef enum logic [1:0] {
      ST_COL  = 2'd0,
      ST_THR  = 2'd1,
      ST_SRCH = 2'd2
   } qs_st_e;
endpackage

// File: rtl/qs_frame.sv
module qs_frame #(
   parameter int DW = 16,
   parameter int W  = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] smp,
   input  logic                 pk_in,
   input  logic                 busy,
   input  logic                 restart,
   output logic                 full,
   output logic signed [DW-1:0] fr [2*W+5]
);
   localparam int N  = 2*W+5;
   localparam int C  = W+2;
   localparam int CW = $clog2(C+1);

   logic          acc;
   logic          armed;
   logic [CW-1:0] fill;
   logic [CW-1:0] cnt;

   assign acc  = smp_vld & ~busy;
   assign full = acc & armed & (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) fr[i] <= '0;
         fill  <= '0;
         cnt   <= '0;
         armed <= 1'b0;
      end else begin
         if (acc) begin
            for (int i = 0; i < N-1; i++) fr[i] <= fr[i+1];
            fr[N-1] <= smp;
            if (fill != CW'(C)) fill <= fill + CW'(1);
         end
         if (restart) begin
            fill  <= '0;
            armed <= 1'b0;
         end else if (acc) begin
            if (armed) begin
               cnt <= cnt - CW'(1);
               if (cnt == CW'(1)) armed <= 1'b0;
            end else if (pk_in && fill == CW'(C)) begin
               armed <= 1'b1;
               cnt   <= CW'(C);
            end
         end
      end
   end

   AST_ARM_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(pk_in && smp_vld && !busy)); // R6
endmodule

// File: rtl/qs_slope_thr.sv
module qs_slope_thr #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic signed [DW-1:0] cur,
   input  logic signed [DW-1:0] prv,
   output logic [DW:0]          thr
);
   localparam int SW = DW+1;

   logic signed [SW-1:0] d;
   logic [SW-1:0]        mag;
   logic [SW-1:0]        mpos;
   logic [SW-1:0]        mneg;

   assign d   = $signed({cur[DW-1], cur}) - $signed({prv[DW-1], prv});
   assign mag = d[SW-1] ? SW'(-d) : SW'(d);
   assign thr = ((mpos < mneg) ? mpos : mneg) >> 3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mpos <= '0;
         mneg <= '0;
      end else if (clr) begin
         mpos <= '0;
         mneg <= '0;
      end else if (en) begin
         if (d > 0 && mag > mpos) mpos <= mag;
         if (d < 0 && mag > mneg) mneg <= mag;
      end
   end

   AST_THR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (SW+3)'(thr) * 8 <= (SW+3)'(mpos) && (SW+3)'(thr) * 8 <= (SW+3)'(mneg)); // R3
endmodule

// File: rtl/qs_cand.sv
module qs_cand #(
   parameter int DW = 16
) (
   input  logic signed [DW-1:0] xm2,
   input  logic signed [DW-1:0] xm1,
   input  logic signed [DW-1:0] x0,
   input  logic signed [DW-1:0] xp1,
   input  logic [DW:0]          thr,
   output logic                 hit
);
   localparam int SW = DW+1;

   logic signed [SW-1:0] s_pre, s_in, s_out;
   logic [SW-1:0]        m_pre, m_in, m_out;
   logic                 flat_or_turn, steep;

   always_comb begin
      s_pre = $signed({xm1[DW-1], xm1}) - $signed({xm2[DW-1], xm2});
      s_in  = $signed({x0[DW-1], x0})   - $signed({xm1[DW-1], xm1});
      s_out = $signed({xp1[DW-1], xp1}) - $signed({x0[DW-1], x0});
      m_pre = s_pre[SW-1] ? SW'(-s_pre) : SW'(s_pre);
      m_in  = s_in[SW-1]  ? SW'(-s_in)  : SW'(s_in);
      m_out = s_out[SW-1] ? SW'(-s_out) : SW'(s_out);
      flat_or_turn = (s_in == 0) || (s_out == 0) ||
                     ((s_in > 0) && (s_out < 0)) || ((s_in < 0) && (s_out > 0));
      steep = (m_pre > thr) && (m_in > thr) && (m_out > thr);
      hit   = flat_or_turn | steep;
   end
endmodule

// File: rtl/qs_locator.sv
module qs_locator
   import qs_pkg::*;
#(
   parameter int DW = 16,
   parameter int W  = 20
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      smp_vld,
   input  logic signed [DW-1:0]      smp,
   input  logic                      pk_in,
   output logic                      busy,
   output logic                      res_vld,
   output logic                      q_fnd,
   output logic signed [DW-1:0]      q_amp,
   output logic [$clog2(W+1)-1:0]    q_off,
   output logic                      s_fnd,
   output logic signed [DW-1:0]      s_amp,
   output logic [$clog2(W+1)-1:0]    s_off
);
   localparam int N  = 2*W+5;
   localparam int C  = W+2;
   localparam int IW = $clog2(N);
   localparam int KW = $clog2(W+1);

   if (W < 3) begin : g_bad_w
      $error("qs_locator: W must be at least 3");
   end
   if (DW < 4) begin : g_bad_dw
      $error("qs_locator: DW must be at least 4");
   end

   qs_st_e               st;
   logic [IW-1:0]        ti;
   logic [KW-1:0]        k;
   logic                 frm_full, restart;
   logic signed [DW-1:0] fr [N];
   logic [DW:0]          thr;

   logic                 hit [2];
   logic                 wf [2], nf [2], of [2];
   logic signed [DW-1:0] wa [2], na [2], oa [2];
   logic [KW-1:0]        wo [2], no [2], oo [2];

   assign busy    = (st != ST_COL);
   assign restart = (st == ST_SRCH) && (k == KW'(W));

   qs_frame #(.DW(DW), .W(W)) u_frm (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .pk_in(pk_in),
      .busy(busy), .restart(restart), .full(frm_full), .fr(fr)
   );

   qs_slope_thr #(.DW(DW)) u_thr (
      .clk(clk), .rst_n(rst_n), .clr(frm_full), .en(st == ST_THR),
      .cur(fr[ti]), .prv(fr[ti - IW'(1)]), .thr(thr)
   );

   for (genvar g = 0; g < 2; g++) begin : g_side
      logic [IW-1:0] j;
      if (g == 0) begin : g_q
         assign j = IW'(C) - IW'(k);
      end else begin : g_s
         assign j = IW'(C) + IW'(k);
      end
      qs_cand #(.DW(DW)) u_cand (
         .xm2(fr[j - IW'(2)]), .xm1(fr[j - IW'(1)]), .x0(fr[j]),
         .xp1(fr[j + IW'(1)]), .thr(thr), .hit(hit[g])
      );
      assign nf[g] = wf[g] | hit[g];
      assign na[g] = wf[g] ? wa[g] : (hit[g] ? fr[j] : '0);
      assign no[g] = wf[g] ? wo[g] : (hit[g] ? k : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_COL;
         ti      <= '0;
         k       <= '0;
         res_vld <= 1'b0;
         for (int g = 0; g < 2; g++) begin
            wf[g] <= 1'b0; wa[g] <= '0; wo[g] <= '0;
            of[g] <= 1'b0; oa[g] <= '0; oo[g] <= '0;
         end
      end else begin
         res_vld <= 1'b0;
         case (st)
            ST_COL: if (frm_full) begin
               st <= ST_THR;
               ti <= IW'(C-W+1);
            end
            ST_THR: begin
               ti <= ti + IW'(1);
               if (ti == IW'(C+W)) begin
                  st <= ST_SRCH;
                  k  <= KW'(1);
                  for (int g = 0; g < 2; g++) begin
                     wf[g] <= 1'b0; wa[g] <= '0; wo[g] <= '0;
                  end
               end
            end
            ST_SRCH: begin
               k <= k + KW'(1);
               for (int g = 0; g < 2; g++) begin
                  wf[g] <= nf[g]; wa[g] <= na[g]; wo[g] <= no[g];
               end
               if (k == KW'(W)) begin
                  for (int g = 0; g < 2; g++) begin
                     of[g] <= nf[g]; oa[g] <= na[g]; oo[g] <= no[g];
                  end
                  res_vld <= 1'b1;
                  st      <= ST_COL;
               end
            end
            default: st <= ST_COL;
         endcase
      end
   end

   assign q_fnd = of[0];
   assign q_amp = oa[0];
   assign q_off = oo[0];
   assign s_fnd = of[1];
   assign s_amp = oa[1];
   assign s_off = oo[1];

   AST_BUSY_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      frm_full |=> busy); // R7
   AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld); // R8
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> $stable(q_amp) && $stable(s_amp) && $stable(q_off) && $stable(s_fnd)); // R8
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld && !q_fnd |-> q_amp == 0 && q_off == 0); // R5
   AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      s_fnd |-> s_off >= KW'(1) && s_off <= KW'(W)); // R1
endmodule

// File: tb/sim_qs_locator.sv
module sim_qs_locator;
   localparam int CLK_NS = 10;
   localparam int DW = 16;
   localparam int W  = 20;
   localparam int N  = 2*W+5;
   localparam int C  = W+2;
   localparam int KW = $clog2(W+1);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 smp_vld = 1'b0;
   logic signed [DW-1:0] smp = '0;
   logic                 pk_in = 1'b0;
   logic                 busy, res_vld, q_fnd, s_fnd;
   logic signed [DW-1:0] q_amp, s_amp;
   logic [KW-1:0]        q_off, s_off;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   int  frm [N];
   int  ef [2], ea [2], eo [2];

   always #(CLK_NS/2) clk = ~clk;

   qs_locator #(.DW(DW), .W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .pk_in(pk_in),
      .busy(busy), .res_vld(res_vld), .q_fnd(q_fnd), .q_amp(q_amp), .q_off(q_off),
      .s_fnd(s_fnd), .s_amp(s_amp), .s_off(s_off)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic bit is_cand(int a, int b, int c, int d, int t);
      int s1, s2, s3;
      bit c1, c2;
      s1 = b - a; s2 = c - b; s3 = d - c;
      c1 = (s2 == 0) || (s3 == 0) || (s2 > 0 && s3 < 0) || (s2 < 0 && s3 > 0);
      c2 = (iabs(s1) > t) && (iabs(s2) > t) && (iabs(s3) > t);
      return c1 || c2;
   endfunction

   task automatic calc_exp();
      int mp, mn, t;
      mp = 0; mn = 0;
      for (int i = C-W+1; i <= C+W; i++) begin
         int d;
         d = frm[i] - frm[i-1];
         if (d > mp) mp = d;
         if (-d > mn) mn = -d;
      end
      t = ((mp < mn) ? mp : mn) >>> 3;
      for (int g = 0; g < 2; g++) begin
         ef[g] = 0; ea[g] = 0; eo[g] = 0;
      end
      for (int kk = 1; kk <= W; kk++) begin
         int jq, js;
         jq = C - kk; js = C + kk;
         if (ef[0] == 0 && is_cand(frm[jq-2], frm[jq-1], frm[jq], frm[jq+1], t)) begin
            ef[0] = 1; ea[0] = frm[jq]; eo[0] = kk;
         end
         if (ef[1] == 0 && is_cand(frm[js-2], frm[js-1], frm[js], frm[js+1], t)) begin
            ef[1] = 1; ea[1] = frm[js]; eo[1] = kk;
         end
      end
   endtask

   task automatic push(int v, bit pk);
      smp_vld = 1'b1; smp = DW'(v); pk_in = pk;
      @(negedge clk);
   endtask

   task automatic idle();
      smp_vld = 1'b0; pk_in = 1'b0;
   endtask

   task automatic run_frame(string tag, int extra, bit dup_pk, bit junk);
      int wait_n;
      for (int i = 0; i < extra; i++) push($urandom_range(0, 200) - 100, 1'b0);
      for (int i = 0; i < N; i++) push(frm[i], (i == C) || (dup_pk && i == C+3));
      idle();
      chk({tag, " R7 busy after frame"}, busy, 1);
      if (junk) begin
         for (int i = 0; i < 6; i++) push($urandom_range(0, 4000) - 2000, 1'b1);
         idle();
      end
      wait_n = 0;
      while (!res_vld && wait_n < 300) begin
         @(negedge clk);
         wait_n++;
      end
      calc_exp();
      chk({tag, " R8 result pulse"}, res_vld, 1);
      chk({tag, " R2 R3 q found"}, q_fnd, ef[0]);
      chk({tag, " R5 R9 q amp"}, q_amp, ea[0]);
      chk({tag, " R4 R1 q offset"}, q_off, eo[0]);
      chk({tag, " R2 R3 s found"}, s_fnd, ef[1]);
      chk({tag, " R5 R9 s amp"}, s_amp, ea[1]);
      chk({tag, " R4 R1 s offset"}, s_off, eo[1]);
      @(negedge clk);
      chk({tag, " R8 pulse ends"}, res_vld, 0);
      chk({tag, " R8 held q amp"}, q_amp, ea[0]);
      chk({tag, " R7 busy clear"}, busy, 0);
   endtask

   task automatic gen_random(int mode);
      int v;
      v = $urandom_range(0, 400) - 200;
      for (int i = 0; i < N; i++) begin
         case (mode)
            0: frm[i] = $urandom_range(0, 400) - 200;
            1: begin
               int inc;
               inc = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 60);
               v = (i <= C) ? v + inc : v - inc;
               frm[i] = v;
            end
            default: frm[i] = (i == C) ? 2000 : $urandom_range(0, 6) - 3;
         endcase
      end
   endtask

   initial begin
      void'($urandom(32'h51A7));
      repeat (3) @(negedge clk);
      chk("R8 reset busy", busy, 0);
      chk("R8 reset res_vld", res_vld, 0);
      chk("R8 reset q_fnd", q_fnd, 0);
      chk("R8 reset s_amp", s_amp, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: peak strobe with too few prior samples is ignored
      for (int i = 0; i < 30; i++) begin
         push(i, (i == 4));
         chk("R6 early peak ignored", busy, 0);
      end
      idle();
      chk("R6 no result from early peak", res_vld, 0);

      // R3: pure ramp, threshold zero, steep rule hits next to peak
      for (int i = 0; i < N; i++) frm[i] = 5 * i;
      run_frame("ramp", 0, 1'b0, 1'b0);

      // R5: slope-one shoulders around a sharp spike, nothing qualifies
      for (int i = 0; i < N; i++) frm[i] = (i < C) ? i : (i == C ? C + 800 : 2*C - i);
      run_frame("none", 0, 1'b0, 1'b0);

      // R1: lone flat step at the far end of the Q window
      for (int i = 0; i < N; i++) frm[i] = (i < C) ? i : (i == C ? C + 800 : 2*C - i);
      frm[1] = frm[2];
      frm[0] = frm[2] - 1;
      run_frame("edge", 0, 1'b0, 1'b0);

      // full-scale alternating samples
      for (int i = 0; i < N; i++) frm[i] = (i % 2 == 0) ? 32767 : -32768;
      run_frame("fullscale", 0, 1'b0, 1'b0);

      // R6 second strobe ignored, R7 input during busy ignored
      gen_random(1);
      run_frame("dup_peak", 3, 1'b1, 1'b0);
      gen_random(0);
      run_frame("busy_junk", 0, 1'b0, 1'b1);

      for (int r = 0; r < 36; r++) begin
         gen_random(r % 3);
         run_frame($sformatf("rand%0d", r), $urandom_range(0, 5), 1'b0, (r % 5 == 0));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule